// File: doc/BRIEF.md
# SDRAM Single-Write Command Sequencer

This block turns one host write request into the command sequence that an SDRAM needs for a single-word write followed by an explicit bank close. The host presents a bank, row, column, data word and byte mask with a valid strobe. When the block is ready, it takes the request and opens the row with ACTIVE. After the row-to-column delay it issues WRITE, with the data and mask driven in the same cycle. It then closes the bank with PRECHARGE. Every other cycle carries NOP.

The device timings are parameters in picoseconds, together with the clock period. At elaboration each one becomes a cycle count by ceiling division, with a floor of one cycle. PRECHARGE lands on whichever is later: write recovery measured from the data cycle, or the minimum row-active time measured from ACTIVE. Ready for the next request returns only when the following ACTIVE would meet both the precharge time and the row-cycle time. Because the bank is always closed a few cycles after it opens, the row-active maximum cannot be reached.

Top module: `sdram_wr_seq`

## Requirements
- R1: During and right after reset the bus carries NOP (CS#,RAS#,CAS#,WE# = 0,1,1,1), CKE is high, BA and address are zero, DQ is undriven with data zero, DQM is all ones, done is low and ready is high.
- R2: A request is taken on a rising edge where reqValid and reqReady are both high. In the next cycle the bus carries ACTIVE (0,0,1,1), with BA set to the request bank and the address set to the request row.
- R3: WRITE (0,1,0,0) appears exactly RCD cycles after ACTIVE, where RCD = max(1, ceil(tRCD/tCK)). It carries the same bank, the column in the low address bits, A10 low and all other address bits zero.
- R4: In the WRITE cycle, and only then, the DQ output enable is high, DQ carries the request data and DQM carries the request mask. In every other cycle DQM is all ones.
- R5: PRECHARGE (0,0,1,0) with A10 low and the same bank appears exactly max(RAS, RCD+WR) cycles after ACTIVE, each count a ceiling division as in R3. A one-cycle done pulse comes in the same cycle.
- R6: Ready is low from the acceptance edge until the cycle before the next ACTIVE is allowed, at max(PRE+RP, RC) cycles after the previous ACTIVE. A request held waiting is accepted there, so back-to-back writes reach exactly that spacing.
- R7: Every cycle other than the three commands of a write carries NOP with BA, address and DQ data at zero. Each accepted request yields exactly one ACTIVE, one WRITE and one PRECHARGE.
- R8: Request inputs that change or stay valid while ready is low have no effect: the WRITE and PRECHARGE use the values captured at acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Host write request |
| reqReady | output | 1 | Request can be taken this cycle |
| reqBank | input | BANK_W | Target bank |
| reqRow | input | ROW_W | Target row |
| reqCol | input | COL_W | Target column |
| reqData | input | DQ_W | Write data word |
| reqMask | input | DM_W | Byte mask, high masks a byte |
| done | output | 1 | Pulses with the PRECHARGE that ends a write |
| sdCke | output | 1 | Clock enable, held high |
| sdCsN | output | 1 | Chip select, active low |
| sdRasN | output | 1 | Row strobe, active low |
| sdCasN | output | 1 | Column strobe, active low |
| sdWeN | output | 1 | Write enable, active low |
| sdBa | output | BANK_W | Bank address |
| sdAddr | output | ADDR_W | Row / column address, bit 10 is the auto-precharge flag |
| sdDq | output | DQ_W | Write data |
| sdDqOe | output | 1 | Data output enable |
| sdDqm | output | DM_W | Data mask |

## Verification
The embedded properties assume the host follows the valid/ready rule and that the timing parameters give a next-ACTIVE spacing of at least three cycles. They also assume the column width stays below bit 10, so the auto-precharge flag never overlaps the column. The stimulus keeps within these limits. It uses the default timing set, converted for an 8 ns clock, and draws random bank, row, column, data and mask values. It keeps valid high with scrambled values while the block is busy, drops it in the cycle before ready returns, and then either raises it at once or waits a random idle gap.

// File: rtl/sdram_wr_pkg.sv
package sdram_wr_pkg;

  // {cs_n, ras_n, cas_n, we_n}
  localparam logic [3:0] CMD_NOP   = 4'b0111;
  localparam logic [3:0] CMD_ACT   = 4'b0011;
  localparam logic [3:0] CMD_WRITE = 4'b0100;
  localparam logic [3:0] CMD_PRE   = 4'b0010;

  typedef enum logic [1:0] {
    PH_IDLE    = 2'd0,
    PH_OPEN    = 2'd1,
    PH_WRITTEN = 2'd2,
    PH_RECOVER = 2'd3
  } phase_e;

  typedef struct packed {
    logic actStb;
    logic wrStb;
    logic preStb;
  } seq_strb_t;

  function automatic int unsigned psToCycles(int unsigned ps, int unsigned clkPs);
    int unsigned n;
    n = (ps + clkPs - 1) / clkPs;
    return (n == 0) ? 1 : n;
  endfunction

  function automatic int unsigned maxOf(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sdram_wr_ctrl.sv
module sdram_wr_ctrl
  import sdram_wr_pkg::*;
#(
  parameter int unsigned RCD_CYC = 2,
  parameter int unsigned PRE_AT  = 5,
  parameter int unsigned NEXT_AT = 8
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      reqValid,
  output logic      reqReady,
  output seq_strb_t strb
);

  localparam int TW = $clog2(NEXT_AT + 1) + 1;
  localparam logic [TW-1:0] WR_LAST   = TW'(RCD_CYC - 1);
  localparam logic [TW-1:0] PRE_LAST  = TW'(PRE_AT - 1);
  localparam logic [TW-1:0] NEXT_LAST = TW'(NEXT_AT - 1);

  phase_e        phase;
  logic [TW-1:0] tick;
  logic          accept;

  always_comb begin
    reqReady = (phase == PH_IDLE) ||
               ((phase == PH_RECOVER) && (tick >= NEXT_LAST));
    accept      = reqValid && reqReady;
    strb.actStb = accept;
    strb.wrStb  = (phase == PH_OPEN)    && (tick == WR_LAST);
    strb.preStb = (phase == PH_WRITTEN) && (tick == PRE_LAST);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase <= PH_IDLE;
      tick  <= '0;
    end else if (accept) begin
      phase <= PH_OPEN;
      tick  <= '0;
    end else begin
      case (phase)
        PH_OPEN: begin
          tick <= tick + 1'b1;
          if (strb.wrStb) phase <= PH_WRITTEN;
        end
        PH_WRITTEN: begin
          tick <= tick + 1'b1;
          if (strb.preStb) phase <= PH_RECOVER;
        end
        PH_RECOVER: begin
          if (tick >= NEXT_LAST) phase <= PH_IDLE;
          else                   tick  <= tick + 1'b1;
        end
        default: tick <= '0;
      endcase
    end
  end

  // R6
  busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> !reqReady);

  // R7
  single_cmd_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.actStb, strb.wrStb, strb.preStb}));

  // R7
  pre_follows_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrStb |=> (phase == PH_WRITTEN) && !reqReady);

endmodule

// File: rtl/sdram_wr_dpath.sv
module sdram_wr_dpath
  import sdram_wr_pkg::*;
#(
  parameter int BANK_W = 2,
  parameter int ROW_W  = 12,
  parameter int COL_W  = 9,
  parameter int ADDR_W = 12,
  parameter int DQ_W   = 16,
  parameter int DM_W   = 2,
  parameter int AP_BIT = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  seq_strb_t         strb,
  input  logic [BANK_W-1:0] reqBank,
  input  logic [ROW_W-1:0]  reqRow,
  input  logic [COL_W-1:0]  reqCol,
  input  logic [DQ_W-1:0]   reqData,
  input  logic [DM_W-1:0]   reqMask,
  output logic [3:0]        cmdQ,
  output logic [BANK_W-1:0] baQ,
  output logic [ADDR_W-1:0] addrQ,
  output logic [DQ_W-1:0]   dqQ,
  output logic              dqOeQ,
  output logic [DM_W-1:0]   dqmQ,
  output logic              doneQ
);

  logic [BANK_W-1:0] bankL;
  logic [COL_W-1:0]  colL;
  logic [DQ_W-1:0]   dataL;
  logic [DM_W-1:0]   maskL;
  logic [ADDR_W-1:0] rowAddr;
  logic [ADDR_W-1:0] colAddr;
  logic [ADDR_W-1:0] preAddr;

  generate
    if (ROW_W < ADDR_W) begin : g_rowPad
      assign rowAddr = {{(ADDR_W-ROW_W){1'b0}}, reqRow};
    end else begin : g_rowFull
      assign rowAddr = reqRow[ADDR_W-1:0];
    end
  endgenerate

  always_comb begin
    colAddr              = '0;
    colAddr[COL_W-1:0]   = colL;
    colAddr[AP_BIT]      = 1'b0;
    preAddr              = '0;
    preAddr[AP_BIT]      = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bankL <= '0;
      colL  <= '0;
      dataL <= '0;
      maskL <= '0;
    end else if (strb.actStb) begin
      bankL <= reqBank;
      colL  <= reqCol;
      dataL <= reqData;
      maskL <= reqMask;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmdQ  <= CMD_NOP;
      baQ   <= '0;
      addrQ <= '0;
      dqQ   <= '0;
      dqOeQ <= 1'b0;
      dqmQ  <= '1;
      doneQ <= 1'b0;
    end else begin
      cmdQ  <= CMD_NOP;
      baQ   <= '0;
      addrQ <= '0;
      dqQ   <= '0;
      dqOeQ <= 1'b0;
      dqmQ  <= '1;
      doneQ <= 1'b0;
      if (strb.actStb) begin
        cmdQ  <= CMD_ACT;
        baQ   <= reqBank;
        addrQ <= rowAddr;
      end else if (strb.wrStb) begin
        cmdQ  <= CMD_WRITE;
        baQ   <= bankL;
        addrQ <= colAddr;
        dqQ   <= dataL;
        dqOeQ <= 1'b1;
        dqmQ  <= maskL;
      end else if (strb.preStb) begin
        cmdQ  <= CMD_PRE;
        baQ   <= bankL;
        addrQ <= preAddr;
        doneQ <= 1'b1;
      end
    end
  end

  // R2
  act_bank_row_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.actStb |=> (baQ == $past(reqBank)) && (addrQ == $past(rowAddr)));

  // R4
  write_data_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrStb |=> dqOeQ && (dqmQ == $past(maskL)) && (dqQ == $past(dataL)));

  // R5
  done_with_pre_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.preStb |=> doneQ && !addrQ[AP_BIT]);

  // R4
  mask_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !dqOeQ |-> (dqmQ == {DM_W{1'b1}}));

endmodule

// File: rtl/sdram_wr_seq.sv
module sdram_wr_seq
  import sdram_wr_pkg::*;
#(
  parameter int BANK_W = 2,
  parameter int ROW_W  = 12,
  parameter int COL_W  = 9,
  parameter int ADDR_W = 12,
  parameter int DQ_W   = 16,
  parameter int DM_W   = 2,
  parameter int unsigned CLK_PS   = 7500,
  parameter int unsigned T_RCD_PS = 15000,
  parameter int unsigned T_WR_PS  = 15000,
  parameter int unsigned T_RAS_PS = 37000,
  parameter int unsigned T_RP_PS  = 15000,
  parameter int unsigned T_RC_PS  = 60000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [BANK_W-1:0] reqBank,
  input  logic [ROW_W-1:0]  reqRow,
  input  logic [COL_W-1:0]  reqCol,
  input  logic [DQ_W-1:0]   reqData,
  input  logic [DM_W-1:0]   reqMask,
  output logic              done,
  output logic              sdCke,
  output logic              sdCsN,
  output logic              sdRasN,
  output logic              sdCasN,
  output logic              sdWeN,
  output logic [BANK_W-1:0] sdBa,
  output logic [ADDR_W-1:0] sdAddr,
  output logic [DQ_W-1:0]   sdDq,
  output logic              sdDqOe,
  output logic [DM_W-1:0]   sdDqm
);

  localparam int unsigned RCD_CYC = psToCycles(T_RCD_PS, CLK_PS);
  localparam int unsigned WR_CYC  = psToCycles(T_WR_PS,  CLK_PS);
  localparam int unsigned RAS_CYC = psToCycles(T_RAS_PS, CLK_PS);
  localparam int unsigned RP_CYC  = psToCycles(T_RP_PS,  CLK_PS);
  localparam int unsigned RC_CYC  = psToCycles(T_RC_PS,  CLK_PS);
  localparam int unsigned PRE_AT  = maxOf(RAS_CYC, RCD_CYC + WR_CYC);
  localparam int unsigned NEXT_AT = maxOf(PRE_AT + RP_CYC, RC_CYC);

  seq_strb_t  strb;
  logic [3:0] cmdQ;

  sdram_wr_ctrl #(
    .RCD_CYC (RCD_CYC),
    .PRE_AT  (PRE_AT),
    .NEXT_AT (NEXT_AT)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .reqReady (reqReady),
    .strb     (strb)
  );

  sdram_wr_dpath #(
    .BANK_W (BANK_W),
    .ROW_W  (ROW_W),
    .COL_W  (COL_W),
    .ADDR_W (ADDR_W),
    .DQ_W   (DQ_W),
    .DM_W   (DM_W),
    .AP_BIT (10)
  ) u_dpath (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .reqBank (reqBank),
    .reqRow  (reqRow),
    .reqCol  (reqCol),
    .reqData (reqData),
    .reqMask (reqMask),
    .cmdQ    (cmdQ),
    .baQ     (sdBa),
    .addrQ   (sdAddr),
    .dqQ     (sdDq),
    .dqOeQ   (sdDqOe),
    .dqmQ    (sdDqm),
    .doneQ   (done)
  );

  assign sdCke = 1'b1;
  assign {sdCsN, sdRasN, sdCasN, sdWeN} = cmdQ;

endmodule

// File: tb/sdram_wr_seq_bench.sv
module sdram_wr_seq_bench;

  localparam int unsigned CLK_PS = 8000;
  localparam int unsigned T_RCD = 15000, T_WR = 15000, T_RAS = 37000,
                          T_RP = 15000, T_RC = 60000;

  function automatic int unsigned toCyc(int unsigned ps);
    int unsigned n;
    n = (ps + CLK_PS - 1) / CLK_PS;
    return (n == 0) ? 1 : n;
  endfunction

  function automatic int unsigned bigger(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction

  localparam int unsigned E_RCD  = toCyc(T_RCD);
  localparam int unsigned E_PRE  = bigger(toCyc(T_RAS), E_RCD + toCyc(T_WR));
  localparam int unsigned E_NEXT = bigger(E_PRE + toCyc(T_RP), toCyc(T_RC));

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic [1:0]  reqBank = '0;
  logic [11:0] reqRow = '0;
  logic [8:0]  reqCol = '0;
  logic [15:0] reqData = '0;
  logic [1:0]  reqMask = '0;
  logic        done, sdCke, sdCsN, sdRasN, sdCasN, sdWeN, sdDqOe;
  logic [1:0]  sdBa, sdDqm;
  logic [11:0] sdAddr;
  logic [15:0] sdDq;

  int compared = 0;
  int mismatched = 0;
  bit finished = 0;

  always #4ns clk = ~clk;

  sdram_wr_seq #(
    .CLK_PS(CLK_PS), .T_RCD_PS(T_RCD), .T_WR_PS(T_WR), .T_RAS_PS(T_RAS),
    .T_RP_PS(T_RP), .T_RC_PS(T_RC)
  ) u_sdram_wr_seq (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqBank(reqBank), .reqRow(reqRow), .reqCol(reqCol), .reqData(reqData),
    .reqMask(reqMask), .done(done), .sdCke(sdCke), .sdCsN(sdCsN),
    .sdRasN(sdRasN), .sdCasN(sdCasN), .sdWeN(sdWeN), .sdBa(sdBa),
    .sdAddr(sdAddr), .sdDq(sdDq), .sdDqOe(sdDqOe), .sdDqm(sdDqm)
  );

  // {cke, cmd[4], ba[2], addr[12], oe, dq[16], dqm[2], done, ready} = 40 bits
  function automatic logic [39:0] pack(logic [3:0] c, logic [1:0] b, logic [11:0] a,
                                       logic oe, logic [15:0] d, logic [1:0] m,
                                       logic dn, logic rdy);
    return {1'b1, c, b, a, oe, d, m, dn, rdy};
  endfunction

  function automatic logic [39:0] seen();
    return {sdCke, sdCsN, sdRasN, sdCasN, sdWeN, sdBa, sdAddr, sdDqOe, sdDq,
            sdDqm, done, reqReady};
  endfunction

  task automatic check(string tag, logic [39:0] act, logic [39:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic idleCycle();
    @(negedge clk);
    // R7 idle NOP, R6 ready stays high when idle
    check("R7 idle", seen(), pack(4'b0111, 2'd0, 12'd0, 1'b0, 16'd0, 2'b11, 1'b0, 1'b1));
  endtask

  task automatic sendTxn(logic [1:0] b, logic [11:0] r, logic [8:0] c,
                         logic [15:0] d, logic [1:0] m);
    logic [39:0] exp;
    logic [11:0] colA;
    string tag;
    reqBank = b; reqRow = r; reqCol = c; reqData = d; reqMask = m; reqValid = 1'b1;
    compared++;
    if (reqReady !== 1'b1) begin
      mismatched++;
      $display("FAIL R6 ready before request actual=%b expected=1", reqReady);
    end
    @(posedge clk);
    colA = {3'b000, c};
    for (int cyc = 0; cyc < int'(E_NEXT); cyc++) begin
      @(negedge clk);
      if (cyc == 0) begin
        // R8 scramble inputs while busy, valid kept high
        reqBank = 2'($urandom); reqRow = 12'($urandom); reqCol = 9'($urandom);
        reqData = 16'($urandom); reqMask = 2'($urandom);
      end
      if (cyc == int'(E_NEXT) - 2) reqValid = 1'b0;
      if (cyc == 0) begin
        tag = "R2";
        exp = pack(4'b0011, b, r, 1'b0, 16'd0, 2'b11, 1'b0, 1'b0);
      end else if (cyc == int'(E_RCD)) begin
        tag = "R3 R4 R8";
        exp = pack(4'b0100, b, colA, 1'b1, d, m, 1'b0, 1'b0);
      end else if (cyc == int'(E_PRE)) begin
        tag = "R5 R8";
        exp = pack(4'b0010, b, 12'd0, 1'b0, 16'd0, 2'b11, 1'b1, 1'b0);
      end else begin
        tag = (cyc == int'(E_NEXT) - 1) ? "R6" : "R7";
        exp = pack(4'b0111, 2'd0, 12'd0, 1'b0, 16'd0, 2'b11, 1'b0,
                   (cyc == int'(E_NEXT) - 1));
      end
      check(tag, seen(), exp);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      mismatched++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R1 reset state while held in reset
    check("R1 in reset", seen(), pack(4'b0111, 2'd0, 12'd0, 1'b0, 16'd0, 2'b11, 1'b0, 1'b1));
    rstN = 1'b1;
    idleCycle();
    check("R1 after reset", seen(), pack(4'b0111, 2'd0, 12'd0, 1'b0, 16'd0, 2'b11, 1'b0, 1'b1));

    // directed corners
    sendTxn(2'd0, 12'h000, 9'h000, 16'h0000, 2'b00);
    idleCycle();
    sendTxn(2'd3, 12'hFFF, 9'h1FF, 16'hFFFF, 2'b11);
    // R6 back-to-back with no gap
    sendTxn(2'd1, 12'hA5A, 9'h155, 16'h1234, 2'b01);
    sendTxn(2'd2, 12'h5A5, 9'h0AA, 16'hBEEF, 2'b10);
    repeat (2) idleCycle();

    // constrained random
    for (int n = 0; n < 60; n++) begin
      int gap;
      sendTxn(2'($urandom), 12'($urandom), 9'($urandom), 16'($urandom), 2'($urandom));
      gap = int'($urandom_range(0, 3));
      for (int g = 0; g < gap; g++) idleCycle();
    end
    repeat (3) idleCycle();

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule